// File: doc/BRIEF.md
# Sleep Mode Entry Sequencer

This block walks the chip from normal operation into a low-power sleep state and back. Software starts it by writing the sleep code into a 2-bit request field of the power-management control register. The sequencer first raises an idle request to the CPU and holds it there until the CPU acknowledges. Only after that acknowledge does it raise one sleep line, which fans out to every peripheral bus interface. How each peripheral reacts to that line is outside this block.

Any wake event returns the chip to run mode. A wake can arrive while the sequencer is still waiting for the CPU. In that case entry is abandoned and the sleep line is never raised. The current mode is always visible on a 2-bit status output. The request field can be read back, and it returns to zero once the chip is back in run mode.

All pins are plain control and status signals. Nothing here carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `sleep_seq_top`

## Requirements
- R1: While the synchronous active-low reset is held, and on the first cycle after it is released, mode_o reads 2'b00 (run), idle_req_o and sleep_o are 0, and req_rd_o reads 2'b00.
- R2: In run mode, a write (cfg_wr_i=1) whose request field cfg_req_i equals 2'b10 moves the sequencer to idle-pending on the next clock edge. From that edge on, idle_req_o=1, mode_o=2'b01 and req_rd_o=2'b10.
- R3: A write in run mode with cfg_req_i equal to 2'b00, 2'b01 or 2'b11 has no effect: the mode stays run and req_rd_o stays 2'b00.
- R4: In idle-pending, sleep_o stays 0 until idle_ack_i is seen at a clock edge with no wake bit set. From the next edge on, mode_o=2'b10 and sleep_o=1, and idle_req_o stays 1 for as long as sleep_o is 1.
- R5: In sleep mode, any set bit of wake_i drops sleep_o in the same cycle, with no clock edge in between. On the next edge the mode returns to run, idle_req_o falls to 0 and req_rd_o reads 2'b00.
- R6: A wake bit seen in idle-pending aborts entry, even if idle_ack_i is high in the same cycle. The next edge returns to run, and sleep_o is never asserted.
- R7: Writes of any value while in idle-pending or sleep mode are ignored. They change neither the mode nor req_rd_o.
- R8: In run mode, wake_i and idle_ack_i have no effect on any output.
- R9: mode_o encodes the mode as 2'b00 run, 2'b01 idle-pending and 2'b10 sleep. The value 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_i | input | 1 | Control register write strobe |
| cfg_req_i | input | 2 | Request field of the written value (2'b10 = sleep) |
| req_rd_o | output | 2 | Read-back of the request field |
| idle_req_o | output | 1 | Idle request to the CPU |
| idle_ack_i | input | 1 | Idle acknowledge from the CPU |
| wake_i | input | N_WAKE | Wake event lines, any set bit wakes |
| sleep_o | output | 1 | Sleep broadcast to all peripheral bus interfaces |
| mode_o | output | 2 | Current mode: 00 run, 01 idle-pending, 10 sleep |

## Verification
A wrong internal mode shows up on mode_o, idle_req_o and req_rd_o at the first clock edge where the state register takes the wrong value. Each of these outputs is a direct function of that register, so the error is visible one cycle after the stimulus that caused it. A missing combinational wake path shows on sleep_o in the very cycle a wake bit rises in sleep mode, before any edge. For that reason the bench compares every output just before each rising edge, with the inputs of that cycle already applied. Ordering faults are caught the same way: a sleep line raised before the acknowledge, an ignored abort, or a write accepted outside run mode each makes sleep_o or mode_o differ from the model within one cycle.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_PEND = 2'b01,
    MODE_SLP  = 2'b10
  } mode_e;

  localparam int REQ_W = 2;
  localparam logic [REQ_W-1:0] REQ_SLEEP = 2'b10;
  localparam logic [REQ_W-1:0] REQ_NONE  = 2'b00;
endpackage

// File: rtl/sleep_wake_merge.sv
module sleep_wake_merge #(
  parameter int N_WAKE = 4
) (
  input  logic [N_WAKE-1:0] wake_i,
  output logic              any_o
);
  logic [N_WAKE:0] chain;

  assign chain[0] = 1'b0;

  // Fold the wake lines into one OR chain, one stage per line.
  for (genvar g = 0; g < N_WAKE; g++) begin : g_or
    assign chain[g+1] = chain[g] | wake_i[g];
  end

  assign any_o = chain[N_WAKE];
endmodule

// File: rtl/sleep_req_decode.sv
module sleep_req_decode
  import sleep_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_i,
  input  logic [REQ_W-1:0] cfg_req_i,
  input  logic             in_run_i,
  input  logic             to_run_i,
  output logic             start_o,
  output logic [REQ_W-1:0] req_rd_o
);
  logic [REQ_W-1:0] req_q;

  // A request counts only in run mode and only with the sleep code.
  assign start_o = cfg_wr_i && in_run_i && (cfg_req_i == REQ_SLEEP);

  always_ff @(posedge clk) begin
    if (!rst_n)        req_q <= REQ_NONE;
    else if (start_o)  req_q <= REQ_SLEEP;
    else if (to_run_i) req_q <= REQ_NONE;
  end

  assign req_rd_o = req_q;

  // R2
  field_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> (req_q == REQ_SLEEP));

  // R5
  field_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    to_run_i |=> (req_q == REQ_NONE));
endmodule

// File: rtl/sleep_mode_fsm.sv
module sleep_mode_fsm
  import sleep_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_i,
  input  logic  idle_ack_i,
  input  logic  wake_i,
  output logic  in_run_o,
  output logic  to_run_o,
  output logic  idle_req_o,
  output logic  sleep_o,
  output mode_e mode_o
);
  mode_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      MODE_RUN:  if (start_i) st_d = MODE_PEND;
      MODE_PEND: begin
        // A wake wins over an acknowledge arriving in the same cycle.
        if (wake_i)          st_d = MODE_RUN;
        else if (idle_ack_i) st_d = MODE_SLP;
      end
      MODE_SLP:  if (wake_i) st_d = MODE_RUN;
      default:   st_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= MODE_RUN;
    else        st_q <= st_d;
  end

  assign in_run_o   = (st_q == MODE_RUN);
  assign to_run_o   = (st_q != MODE_RUN) && (st_d == MODE_RUN);
  assign idle_req_o = (st_q != MODE_RUN);
  // The wake path into the sleep line has no register.
  assign sleep_o    = (st_q == MODE_SLP) && !wake_i;
  assign mode_o     = st_q;

  // R4
  sleep_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == MODE_SLP) |-> ($past(st_q) == MODE_PEND) && $past(idle_ack_i));

  // R4
  sleep_holds_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> idle_req_o);

  // R5
  wake_drops_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_i |-> !sleep_o);

  // R6
  abort_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MODE_PEND && wake_i) |=> (st_q == MODE_RUN));

  // R7
  busy_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MODE_SLP && !wake_i) |=> (st_q == MODE_SLP));

  // R9
  legal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != 2'b11);
endmodule

// File: rtl/sleep_seq_top.sv
module sleep_seq_top
  import sleep_seq_pkg::*;
#(
  parameter int N_WAKE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_i,
  input  logic [1:0]        cfg_req_i,
  output logic [1:0]        req_rd_o,
  output logic              idle_req_o,
  input  logic              idle_ack_i,
  input  logic [N_WAKE-1:0] wake_i,
  output logic              sleep_o,
  output logic [1:0]        mode_o
);
  logic  wake_any, start, in_run, to_run;
  mode_e mode;

  sleep_wake_merge #(.N_WAKE(N_WAKE)) u_wake (
    .wake_i (wake_i),
    .any_o  (wake_any)
  );

  sleep_req_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_i  (cfg_wr_i),
    .cfg_req_i (cfg_req_i),
    .in_run_i  (in_run),
    .to_run_i  (to_run),
    .start_o   (start),
    .req_rd_o  (req_rd_o)
  );

  sleep_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .idle_ack_i (idle_ack_i),
    .wake_i     (wake_any),
    .in_run_o   (in_run),
    .to_run_o   (to_run),
    .idle_req_o (idle_req_o),
    .sleep_o    (sleep_o),
    .mode_o     (mode)
  );

  assign mode_o = mode;

  // R8
  run_ignores_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RUN && !(cfg_wr_i && cfg_req_i == REQ_SLEEP)) |=> (mode_o == 2'b00));
endmodule

// File: tb/sleep_seq_top_test.sv
module sleep_seq_top_test;
  localparam int NW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_wr;
  logic [1:0]    cfg_req;
  logic [1:0]    req_rd;
  logic          idle_req;
  logic          idle_ack;
  logic [NW-1:0] wake;
  logic          sleep;
  logic [1:0]    mode;

  int vectors = 0;
  int errors  = 0;
  int m_state = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  sleep_seq_top #(.N_WAKE(NW)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_i   (cfg_wr),
    .cfg_req_i  (cfg_req),
    .req_rd_o   (req_rd),
    .idle_req_o (idle_req),
    .idle_ack_i (idle_ack),
    .wake_i     (wake),
    .sleep_o    (sleep),
    .mode_o     (mode)
  );

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Apply one cycle of inputs, compare against the model, then advance the model.
  task automatic step(input string tag, input bit r, input bit wr, input logic [1:0] rq,
                      input bit ack, input logic [NW-1:0] wk);
    @(negedge clk);
    rst_n = r; cfg_wr = wr; cfg_req = rq; idle_ack = ack; wake = wk;
    #3;
    cmp(tag, "mode", int'(mode), m_state);
    cmp(tag, "idle_req", int'(idle_req), (m_state != 0) ? 1 : 0);
    cmp(tag, "sleep", int'(sleep), (m_state == 2 && wk == '0) ? 1 : 0);
    cmp(tag, "req_rd", int'(req_rd), (m_state != 0) ? 2 : 0);
    @(posedge clk);
    if (!r) m_state = 0;
    else begin
      case (m_state)
        0: if (wr && rq == 2'b10) m_state = 1;
        1: if (wk != '0) m_state = 0; else if (ack) m_state = 2;
        2: if (wk != '0) m_state = 0;
        default: m_state = 0;
      endcase
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_req = 2'b00; idle_ack = 1'b0; wake = '0;
    @(posedge clk);
    // R1 reset state, with distracting inputs held
    step("R1", 0, 1, 2'b10, 1, 4'b0000);
    step("R1", 0, 0, 2'b00, 0, 4'b0000);
    step("R1", 1, 0, 2'b00, 0, 4'b0000);
    // R8 wake and acknowledge in run mode
    step("R8", 1, 0, 2'b00, 1, 4'b0000);
    step("R8", 1, 0, 2'b00, 0, 4'b1010);
    step("R8", 1, 0, 2'b00, 0, 4'b0000);
    // R3 other request codes
    step("R3", 1, 1, 2'b00, 0, 4'b0000);
    step("R3", 1, 1, 2'b01, 0, 4'b0000);
    step("R3", 1, 1, 2'b11, 0, 4'b0000);
    step("R3", 1, 0, 2'b10, 0, 4'b0000);
    // R2 accepted request
    step("R2", 1, 1, 2'b10, 0, 4'b0000);
    // R7 writes ignored while pending; R4 waiting for acknowledge
    step("R7", 1, 1, 2'b10, 0, 4'b0000);
    step("R7", 1, 1, 2'b00, 0, 4'b0000);
    step("R4", 1, 0, 2'b00, 0, 4'b0000);
    step("R4", 1, 0, 2'b00, 1, 4'b0000);
    step("R9", 1, 0, 2'b00, 0, 4'b0000);
    step("R7", 1, 1, 2'b00, 0, 4'b0000);
    step("R7", 1, 1, 2'b10, 1, 4'b0000);
    // R5 wake out of sleep
    step("R5", 1, 0, 2'b00, 0, 4'b0100);
    step("R5", 1, 0, 2'b00, 0, 4'b0000);
    // R5 each wake line in turn
    for (int i = 0; i < NW; i++) begin
      step("R2", 1, 1, 2'b10, 0, 4'b0000);
      step("R4", 1, 0, 2'b00, 1, 4'b0000);
      step("R5", 1, 0, 2'b00, 1, 4'(1 << i));
      step("R5", 1, 0, 2'b00, 0, 4'b0000);
    end
    // R6 abort while pending, wake wins over a simultaneous acknowledge
    step("R2", 1, 1, 2'b10, 0, 4'b0000);
    step("R6", 1, 0, 2'b00, 1, 4'b0001);
    step("R6", 1, 0, 2'b00, 1, 4'b0000);
    step("R6", 1, 0, 2'b00, 0, 4'b0000);
    // R6 abort with no acknowledge
    step("R2", 1, 1, 2'b10, 0, 4'b0000);
    step("R6", 1, 0, 2'b00, 0, 4'b1000);
    step("R6", 1, 0, 2'b00, 0, 4'b0000);
    // R1 reset from sleep
    step("R2", 1, 1, 2'b10, 0, 4'b0000);
    step("R4", 1, 0, 2'b00, 1, 4'b0000);
    step("R1", 0, 0, 2'b00, 0, 4'b0000);
    step("R1", 1, 0, 2'b00, 0, 4'b0000);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule